// File: doc/BRIEF.md
# Ripple Magnitude Comparator

This block decides whether one unsigned operand is greater than, equal to or less than another. It is built as a chain of identical one-bit cells. The cell for the least significant bit sees the block's cascade inputs. Every higher cell sees the greater and less flags of the cell just below it. Each cell compares its own pair of operand bits, and the cell at the top position drives the block outputs.

A cell that finds its two bits different settles the result at its own position. A cell whose two bits match passes on whatever the lower positions decided. Because of this, a difference in a high bit always wins over any difference below it.

The cascade inputs let two instances form one wider comparison. The upper half's cascade inputs are driven from the lower half's greater and less outputs. When the cascade inputs are both low, the block acts as a plain comparator. Driving both cascade inputs high at once is not allowed, and the outputs for that case are not defined. The logic is purely combinational. A parameter selects how each cell is built: either as sum-of-products gates or as a select between its own verdict and the incoming flags.

Top module: `mag_cmp_chain`

## Requirements
- R1: A cell raises its greater output when its X bit is 1 and its Y bit is 0. It also raises it when its two bits are equal and its incoming greater flag is 1.
- R2: A cell raises its less output when its X bit is 0 and its Y bit is 1. It also raises it when its two bits are equal and its incoming less flag is 1.
- R3: A cell raises its equal output only when its two bits match and both incoming flags are 0. Whenever equal is 1, greater and less are both 0.
- R4: The cascade inputs feed bit 0, and the outputs come from bit WIDTH-1. A mismatch at the most significant bit sets the result no matter what the lower bits and the cascade inputs are.
- R5: With both cascade inputs at 0, the outputs follow unsigned X>Y, X==Y and X<Y. Exactly one of the three outputs is 1.
- R6: When X equals Y, a 1 on the greater cascade input gives greater=1, equal=0, less=0. A 1 on the less cascade input gives less=1, equal=0, greater=0. When X differs from Y, the cascade inputs have no effect.
- R7: Two 4-bit instances in series give the same outputs as one 8-bit instance. In the series connection, the lower instance takes bits 3:0 and its greater and less outputs drive the upper instance's cascade inputs.
- R8: WIDTH defaults to 4 and must be at least 1. For any legal cascade input, the greater and less outputs are never both 1, and wider instances follow R5 and R6.
- R9: The two cell forms, sum-of-products (CELL_FORM=CELL_SOP) and select (CELL_FORM=CELL_MUX), give identical outputs for every input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_x | input | WIDTH | Unsigned operand X |
| opnd_y | input | WIDTH | Unsigned operand Y |
| casc_gt_in | input | 1 | Greater flag from a lower-significance stage; tie to 0 when unused |
| casc_lt_in | input | 1 | Less flag from a lower-significance stage; tie to 0 when unused |
| cmp_gt | output | 1 | X is greater, after the cascade input is taken into account |
| cmp_eq | output | 1 | X equals Y and no cascade flag is set |
| cmp_lt | output | 1 | X is less, after the cascade input is taken into account |

## Verification
The bench runs every 4-bit operand pair under each of the three legal cascade settings. A chain with the wrong bit order would let a low-bit difference beat a high-bit one. A cell that drops its incoming flag would report equal when a lower stage had already decided. The same stimulus drives the select-form cell, so any difference between the two cell forms shows up as a mismatch. At 8 bits, a direct instance and a series-joined pair of 4-bit instances are both checked against the built-in operators. These checks use random operands plus 0x80 against 0x7F, the all-zero and all-one extremes, and operands that differ only in bit 3 or bit 4, which is where the cascade link between the two halves gets exercised.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

   // Implementation choice for each one-bit cell
   typedef enum logic {
      CELL_SOP = 1'b0,   // sum-of-products gates
      CELL_MUX = 1'b1    // select between own verdict and incoming flags
   } cell_form_e;

   // Flags passed from one significance position to the next
   typedef struct packed {
      logic gt;
      logic lt;
   } casc_t;

endpackage

// File: rtl/cmp_bit_cell.sv
module cmp_bit_cell
   import cmp_pkg::*;
#(
   parameter cell_form_e FORM = CELL_SOP
) (
   input  logic  x_bit,
   input  logic  y_bit,
   input  casc_t from_low,
   output casc_t to_high,
   output logic  eq_out
);

   logic bits_match;
   assign bits_match = ~(x_bit ^ y_bit);

   generate
      if (FORM == CELL_SOP) begin : g_sop
         assign to_high.gt = (x_bit & ~y_bit) | (x_bit & from_low.gt) | (~y_bit & from_low.gt);
         assign to_high.lt = (~x_bit & y_bit) | (~x_bit & from_low.lt) | (y_bit & from_low.lt);
      end else begin : g_mux
         always_comb begin
            if (bits_match) begin
               to_high = from_low;
            end else begin
               to_high.gt = x_bit;
               to_high.lt = y_bit;
            end
         end
      end
   endgenerate

   assign eq_out = bits_match & ~from_low.gt & ~from_low.lt;

   // Cell-level checks on the flags this position produces
   always_comb begin
      if (x_bit && !y_bit)
         a_r1_bit_win_gt : assert (to_high.gt && !to_high.lt);
      if (!x_bit && y_bit)
         a_r2_bit_win_lt : assert (to_high.lt && !to_high.gt);
      if (eq_out)
         a_r3_eq_excl : assert (!to_high.gt && !to_high.lt);
   end

endmodule

// File: rtl/cmp_ripple_chain.sv
module cmp_ripple_chain
   import cmp_pkg::*;
#(
   parameter int         WIDTH = 4,
   parameter cell_form_e FORM  = CELL_SOP
) (
   input  logic [WIDTH-1:0] vec_x,
   input  logic [WIDTH-1:0] vec_y,
   input  casc_t            seed,
   output casc_t            top_flags,
   output logic             top_eq
);

   localparam int LINKS = WIDTH + 1;

   casc_t            link [LINKS];
   logic [WIDTH-1:0] eq_vec;

   assign link[0] = seed;

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_cell
         cmp_bit_cell #(.FORM(FORM)) u_cell (
            .x_bit   (vec_x[i]),
            .y_bit   (vec_y[i]),
            .from_low(link[i]),
            .to_high (link[i+1]),
            .eq_out  (eq_vec[i])
         );
      end
   endgenerate

   assign top_flags = link[WIDTH];
   assign top_eq    = eq_vec[WIDTH-1];

endmodule

// File: rtl/mag_cmp_chain.sv
module mag_cmp_chain
   import cmp_pkg::*;
#(
   parameter int         WIDTH     = 4,
   parameter cell_form_e CELL_FORM = CELL_SOP
) (
   input  logic [WIDTH-1:0] opnd_x,
   input  logic [WIDTH-1:0] opnd_y,
   input  logic             casc_gt_in,
   input  logic             casc_lt_in,
   output logic             cmp_gt,
   output logic             cmp_eq,
   output logic             cmp_lt
);

   localparam int MSB = WIDTH - 1;

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("mag_cmp_chain: WIDTH must be at least 1");
      end
   endgenerate

   casc_t seed_in;
   casc_t msb_out;
   logic  msb_eq;

   assign seed_in.gt = casc_gt_in;
   assign seed_in.lt = casc_lt_in;

   cmp_ripple_chain #(.WIDTH(WIDTH), .FORM(CELL_FORM)) u_chain (
      .vec_x    (opnd_x),
      .vec_y    (opnd_y),
      .seed     (seed_in),
      .top_flags(msb_out),
      .top_eq   (msb_eq)
   );

   assign cmp_gt = msb_out.gt;
   assign cmp_lt = msb_out.lt;
   assign cmp_eq = msb_eq;

   // Block-level checks relating operands, cascade inputs and outputs
   always_comb begin
      if (!(casc_gt_in && casc_lt_in)) begin
         a_r5_one_verdict : assert ($onehot({cmp_gt, cmp_eq, cmp_lt}));
         a_r8_no_gt_and_lt : assert (!(cmp_gt && cmp_lt));
      end
      if (opnd_x[MSB] && !opnd_y[MSB])
         a_r4_msb_decides_gt : assert (cmp_gt);
      if (!opnd_x[MSB] && opnd_y[MSB])
         a_r4_msb_decides_lt : assert (cmp_lt);
      if ((opnd_x == opnd_y) && casc_gt_in && !casc_lt_in)
         a_r6_pass_gt : assert (cmp_gt && !cmp_eq);
      if ((opnd_x == opnd_y) && casc_lt_in && !casc_gt_in)
         a_r6_pass_lt : assert (cmp_lt && !cmp_eq);
   end

endmodule

// File: tb/mag_cmp_chain_tb.sv
module mag_cmp_chain_tb;
   import cmp_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   // shared stimulus
   logic [3:0] x4, y4;
   logic [7:0] x8, y8;
   logic       gi, li;

   logic g4, e4, l4, gm, em, lm, g8, e8, l8;
   logic glo, elo, llo, ghi, ehi, lhi;

   mag_cmp_chain #(.WIDTH(4), .CELL_FORM(CELL_SOP)) u_dut (
      .opnd_x(x4), .opnd_y(y4), .casc_gt_in(gi), .casc_lt_in(li),
      .cmp_gt(g4), .cmp_eq(e4), .cmp_lt(l4));

   mag_cmp_chain #(.WIDTH(4), .CELL_FORM(CELL_MUX)) u_mux (
      .opnd_x(x4), .opnd_y(y4), .casc_gt_in(gi), .casc_lt_in(li),
      .cmp_gt(gm), .cmp_eq(em), .cmp_lt(lm));

   mag_cmp_chain #(.WIDTH(8)) u_wide (
      .opnd_x(x8), .opnd_y(y8), .casc_gt_in(gi), .casc_lt_in(li),
      .cmp_gt(g8), .cmp_eq(e8), .cmp_lt(l8));

   // R7: two 4-bit halves in series
   mag_cmp_chain #(.WIDTH(4)) u_lo (
      .opnd_x(x8[3:0]), .opnd_y(y8[3:0]), .casc_gt_in(gi), .casc_lt_in(li),
      .cmp_gt(glo), .cmp_eq(elo), .cmp_lt(llo));

   mag_cmp_chain #(.WIDTH(4)) u_hi (
      .opnd_x(x8[7:4]), .opnd_y(y8[7:4]), .casc_gt_in(glo), .casc_lt_in(llo),
      .cmp_gt(ghi), .cmp_eq(ehi), .cmp_lt(lhi));

   typedef struct {
      string      req;
      logic [3:0] xa, ya;
      logic [7:0] xb, yb;
      logic [2:0] exp4;
      logic [2:0] exp8;
   } item_t;

   item_t sb_q[$];
   int checks = 0;
   int errors = 0;
   bit done = 0;

   // reference {gt,eq,lt} from the requirements
   function automatic logic [2:0] ref_cmp(input logic [7:0] a, input logic [7:0] b,
                                          input logic cg, input logic cl);
      if (a > b)       return 3'b100;
      else if (a < b)  return 3'b001;
      else if (cg)     return 3'b100;
      else if (cl)     return 3'b001;
      else             return 3'b010;
   endfunction

   task automatic drive(input string req, input logic [3:0] a4, input logic [3:0] b4,
                        input logic [7:0] a8, input logic [7:0] b8,
                        input logic cg, input logic cl);
      item_t it;
      @(negedge clk);
      x4 = a4; y4 = b4; x8 = a8; y8 = b8; gi = cg; li = cl;
      it.req  = req;
      it.xa = a4; it.ya = b4; it.xb = a8; it.yb = b8;
      it.exp4 = ref_cmp({4'd0, a4}, {4'd0, b4}, cg, cl);
      it.exp8 = ref_cmp(a8, b8, cg, cl);
      sb_q.push_back(it);
   endtask

   task automatic cmp_one(input string req, input string who, input logic [2:0] got,
                          input logic [2:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s got %b expected %b", req, who, got, exp);
      end
   endtask

   // monitor: pop and compare at the edge after each drive
   always @(posedge clk) begin
      if (sb_q.size() > 0) begin
         item_t it;
         it = sb_q.pop_front();
         cmp_one(it.req, "sop4", {g4, e4, l4}, it.exp4);
         cmp_one({it.req, "/R9"}, "mux4", {gm, em, lm}, it.exp4);
         cmp_one({it.req, "/R8"}, "wide8", {g8, e8, l8}, it.exp8);
         cmp_one({it.req, "/R7"}, "series8", {ghi, ehi, lhi}, it.exp8);
      end
   end

   initial begin
      x4 = '0; y4 = '0; x8 = '0; y8 = '0; gi = 1'b0; li = 1'b0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // idle state: zero operands, no cascade -> equal (R5)
      drive("R5", 4'd0, 4'd0, 8'd0, 8'd0, 1'b0, 1'b0);

      // exhaustive 4-bit, all three legal cascade settings (R1 R2 R3 R5 R6)
      for (int c = 0; c < 3; c++) begin
         for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
               logic [7:0] ra, rb;
               ra = 8'($urandom);
               rb = (a[0]) ? ra : 8'($urandom);
               drive((c == 0) ? "R5" : "R6", 4'(a), 4'(b), ra, rb, c == 1, c == 2);
            end
         end
      end

      // R4: MSB difference dominates lower bits and cascade
      drive("R4", 4'b1000, 4'b0111, 8'h80, 8'h7F, 1'b0, 1'b1);
      drive("R4", 4'b0111, 4'b1000, 8'h7F, 8'h80, 1'b1, 1'b0);
      drive("R4", 4'b1111, 4'b0000, 8'hFF, 8'h00, 1'b0, 1'b0);
      drive("R4", 4'b0000, 4'b1111, 8'h00, 8'hFF, 1'b0, 1'b0);
      // R7: differences just at the seam of the two halves
      drive("R7", 4'b0001, 4'b0001, 8'h10, 8'h08, 1'b0, 1'b0);
      drive("R7", 4'b0001, 4'b0001, 8'h08, 8'h10, 1'b0, 1'b0);
      drive("R7", 4'b0001, 4'b0001, 8'h5A, 8'h5A, 1'b1, 1'b0);
      drive("R7", 4'b0001, 4'b0001, 8'hA5, 8'hA5, 1'b0, 1'b1);
      drive("R3", 4'b1010, 4'b1010, 8'hC3, 8'hC3, 1'b0, 1'b0);

      // R8: random wide operands, mixed cascade
      for (int k = 0; k < 400; k++) begin
         logic [7:0] ra, rb;
         int cs;
         ra = 8'($urandom);
         rb = (k % 5 == 0) ? ra : 8'($urandom);
         cs = k % 3;
         drive("R8", ra[3:0], rb[3:0], ra, rb, cs == 1, cs == 2);
      end

      @(negedge clk);
      @(negedge clk);
      done = 1;
   end

   initial begin
      int cyc;
      cyc = 0;
      while (!done && cyc < WATCHDOG) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired after %0d cycles", cyc);
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule